// File: doc/BRIEF.md
# Descriptor-Chain DMA Engine

This block moves 32-bit words between the card's local memory and host memory. Each transfer follows a chain of descriptors held in host memory. There are two directions. The inbound direction copies host words into local memory. The outbound direction copies local words out to host memory. Each direction has its own chain pointer and its own enable bit. Software starts, stops or cancels work by writing command codes to a control register. It watches progress through a status register. A one-cycle completion event and a separate one-cycle chain-fault event go to the interrupt logic.

A descriptor is three consecutive little-endian words at the chain pointer:
- offset +0: the local word address;
- offset +4: the host word address;
- offset +8: the length word.

Bits [LEN_W-1:0] of the length word count the words to move. Bit 31 marks the final descriptor, and the next descriptor follows 12 bytes later. Only one chain runs at a time. A start for the other direction waits until the running chain has finished.

The sequencer has these states:
- IDLE: waits for work.
- FETCH: reads the three descriptor words.
- CHECK: validates the length.
- SRC: reads one source word.
- DST: writes one destination word.
- SEG_END: descriptor boundary.
- DONE: completion pulse.
- FAULT: chain-fault pulse.

Its transitions are:
- IDLE to FETCH, on a pending direction.
- IDLE stays in IDLE while acknowledging a stop.
- FETCH to CHECK, after the third word.
- CHECK to FAULT, on zero length.
- CHECK to SRC.
- SRC to DST, on the source acknowledge.
- DST to SRC, while words remain.
- DST to SEG_END, after the last word.
- SEG_END to DONE, on the final flag.
- SEG_END to IDLE, on a pending stop.
- SEG_END to FAULT, on the eighth unterminated descriptor.
- SEG_END to FETCH, for the next descriptor.
- DONE to IDLE and FAULT to IDLE.
- Any state to IDLE on cancel.

Top module: `ll_dma_engine`

## Requirements
- R1: The register word index is `reg_addr[4:2]`: 0 is control (write-only, reads 0), 1 is status, 2 is the inbound chain pointer, 3 is the outbound chain pointer, 4 is the enable register (bit 0 inbound, bit 1 outbound). After reset, status, both pointers and enable read 0, and the pointers and enable read back what was written.
- R2: Status bit 0 is inbound busy and bit 1 is outbound busy. Writing 1 to control starts the inbound chain and writing 2 starts the outbound chain. The busy bit reads 1 on the cycle after the write when that direction is enabled.
- R3: A start for a direction whose enable bit is 0 is ignored: the busy bit stays 0 and no memory request is issued.
- R4: A descriptor is the words at pointer+0 (local address), +4 (host address) and +8 (length). Length bits [15:0] count words, length bit 31 marks the final descriptor, and the next descriptor starts at pointer+12.
- R5: Inbound copies `length` words from ascending host addresses to ascending local addresses, step 4. Outbound copies from local to host the same way. Every request is held with a stable address until acknowledged, and never both ports at once.
- R6: After the final descriptor's last word, `done_evt` pulses for exactly one cycle and that direction's busy bit clears.
- R7: A descriptor whose length bits [15:0] are zero moves no data. It sets status bit 4 (chain fault) and the direction's error bit (bit 2 inbound, bit 3 outbound), pulses `llerr_evt` for one cycle and clears the busy bit.
- R8: A chain whose 8th descriptor lacks the final flag faults as in R7 after that descriptor's data has moved. No 9th descriptor is fetched.
- R9: Writing 0 to control cancels: on the next cycle both memory requests are low and status reads 0 (busy and error bits cleared). No completion event follows.
- R10: Writing 4 to control stops at the next descriptor boundary. The descriptor in progress finishes, no further descriptor is fetched, the busy bits clear, no completion event fires and the error bits are kept.
- R11: A start for the other direction, issued while one chain is busy, is held pending and served after the running chain ends.
- R12: Error bits persist through later successful chains and are cleared only by a cancel.
- R13: Control values other than 0, 1, 2 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hst_req | output | 1 | Host memory request |
| hst_we | output | 1 | Host request is a write |
| hst_addr | output | 32 | Host byte address |
| hst_wdata | output | 32 | Host write data |
| hst_ack | input | 1 | Host acknowledge (one cycle) |
| hst_rdata | input | 32 | Host read data, valid with acknowledge |
| loc_req | output | 1 | Local memory request |
| loc_we | output | 1 | Local request is a write |
| loc_addr | output | 24 | Local byte address |
| loc_wdata | output | 32 | Local write data |
| loc_ack | input | 1 | Local acknowledge (one cycle) |
| loc_rdata | input | 32 | Local read data, valid with acknowledge |
| done_evt | output | 1 | Chain completion pulse |
| llerr_evt | output | 1 | Chain fault pulse |

## Verification
The assertions take several things for granted about the inputs:
- each memory port returns a single-cycle acknowledge only while its request is high;
- register writes are single-cycle strobes;
- software writes a command only after the previous one has taken effect.

The bench's memory models assert acknowledge only against a live request, after a fixed latency, and drop it the following cycle. All register traffic goes through one task that holds the strobe for exactly one clock. The hold-until-acknowledge property is disabled in the cycle of a cancel, since that is the one legal way a request is withdrawn.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_SRC,
        ST_DST,
        ST_SEG_END,
        ST_DONE,
        ST_FAULT
    } dma_state_e;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } dma_dir_e;

    localparam logic [2:0] IDX_CTRL = 3'd0;
    localparam logic [2:0] IDX_STAT = 3'd1;
    localparam logic [2:0] IDX_IPTR = 3'd2;
    localparam logic [2:0] IDX_OPTR = 3'd3;
    localparam logic [2:0] IDX_EN   = 3'd4;

    localparam logic [31:0] CMD_CANCEL = 32'd0;
    localparam logic [31:0] CMD_STOP   = 32'd4;

    localparam int LAST_BIT   = 31;
    localparam int DESC_WORDS = 3;

endpackage

// File: rtl/ll_dma_regs.sv
module ll_dma_regs
    import ll_dma_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int NDIR   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NDIR-1:0]   fin,
    input  logic [NDIR-1:0]   fault,
    input  logic              stop_ack,
    output logic [NDIR-1:0]   busy,
    output logic [NDIR-1:0]   enable,
    output logic              stop_q,
    output logic              cancel,
    output logic [31:0]       in_ptr,
    output logic [31:0]       out_ptr,
    output logic [31:0]       status
);

    logic [2:0]      widx;
    logic            ctrl_wr;
    logic            stop_cmd;
    logic [NDIR-1:0] start_cmd;
    logic [NDIR-1:0] err;
    logic            chain_err;

    assign widx     = reg_addr[4:2];
    assign ctrl_wr  = reg_we && (widx == IDX_CTRL);
    assign cancel   = ctrl_wr && (reg_wdata == CMD_CANCEL);
    assign stop_cmd = ctrl_wr && (reg_wdata == CMD_STOP);

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        assign start_cmd[d] = ctrl_wr && (reg_wdata == (32'd1 << d));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[d] <= 1'b0;
                err[d]  <= 1'b0;
            end else begin
                if (cancel || fin[d] || stop_ack) begin
                    busy[d] <= 1'b0;
                end else if (start_cmd[d] && enable[d]) begin
                    busy[d] <= 1'b1;
                end
                if (cancel) begin
                    err[d] <= 1'b0;
                end else if (fault[d]) begin
                    err[d] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ptr    <= '0;
            out_ptr   <= '0;
            enable    <= '0;
            stop_q    <= 1'b0;
            chain_err <= 1'b0;
        end else begin
            if (reg_we && widx == IDX_IPTR) in_ptr  <= reg_wdata;
            if (reg_we && widx == IDX_OPTR) out_ptr <= reg_wdata;
            if (reg_we && widx == IDX_EN)   enable  <= reg_wdata[NDIR-1:0];
            if (cancel || stop_ack) begin
                stop_q <= 1'b0;
            end else if (stop_cmd) begin
                stop_q <= 1'b1;
            end
            if (cancel) begin
                chain_err <= 1'b0;
            end else if (|fault) begin
                chain_err <= 1'b1;
            end
        end
    end

    assign status = {27'd0, chain_err, err, busy};

    always_comb begin
        unique case (widx)
            IDX_STAT: reg_rdata = status;
            IDX_IPTR: reg_rdata = in_ptr;
            IDX_OPTR: reg_rdata = out_ptr;
            IDX_EN:   reg_rdata = {{(32-NDIR){1'b0}}, enable};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ll_dma_seq.sv
module ll_dma_seq
    import ll_dma_pkg::*;
#(
    parameter int HOST_AW  = 32,
    parameter int LOC_AW   = 24,
    parameter int LEN_W    = 16,
    parameter int MAX_DESC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         busy,
    input  logic               stop_q,
    input  logic               cancel,
    input  logic [31:0]        in_ptr,
    input  logic [31:0]        out_ptr,
    output logic [1:0]         fin,
    output logic [1:0]         fault,
    output logic               stop_ack,
    output logic               hst_req,
    output logic               hst_we,
    output logic [HOST_AW-1:0] hst_addr,
    output logic [31:0]        hst_wdata,
    input  logic               hst_ack,
    input  logic [31:0]        hst_rdata,
    output logic               loc_req,
    output logic               loc_we,
    output logic [LOC_AW-1:0]  loc_addr,
    output logic [31:0]        loc_wdata,
    input  logic               loc_ack,
    input  logic [31:0]        loc_rdata,
    output logic               done_evt,
    output logic               llerr_evt
);

    localparam int CNT_W     = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
    localparam int DESC_BYTE = DESC_WORDS * 4;

    dma_state_e         state_q, state_d;
    dma_dir_e           dir_q;
    logic [HOST_AW-1:0] desc_ptr;
    logic [1:0]         wsel;
    logic [CNT_W-1:0]   desc_cnt;
    logic [LOC_AW-1:0]  laddr;
    logic [HOST_AW-1:0] haddr;
    logic [LEN_W-1:0]   remain;
    logic               last_q;
    logic [31:0]        data_q;
    logic               src_ack, dst_ack;

    assign src_ack = (dir_q == DIR_OUT) ? loc_ack : hst_ack;
    assign dst_ack = (dir_q == DIR_OUT) ? hst_ack : loc_ack;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!stop_q && |busy) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (hst_ack && wsel == 2'(DESC_WORDS - 1)) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                state_d = (remain == '0) ? ST_FAULT : ST_SRC;
            end
            ST_SRC: begin
                if (src_ack) state_d = ST_DST;
            end
            ST_DST: begin
                if (dst_ack) state_d = (remain == LEN_W'(1)) ? ST_SEG_END : ST_SRC;
            end
            ST_SEG_END: begin
                if (last_q)                                state_d = ST_DONE;
                else if (stop_q)                           state_d = ST_IDLE;
                else if (desc_cnt == CNT_W'(MAX_DESC - 1)) state_d = ST_FAULT;
                else                                       state_d = ST_FETCH;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (cancel) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= DIR_IN;
            desc_ptr <= '0;
            wsel     <= '0;
            desc_cnt <= '0;
            laddr    <= '0;
            haddr    <= '0;
            remain   <= '0;
            last_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    dir_q    <= busy[0] ? DIR_IN : DIR_OUT;
                    desc_ptr <= HOST_AW'(busy[0] ? in_ptr : out_ptr);
                    wsel     <= '0;
                    desc_cnt <= '0;
                end
                ST_FETCH: begin
                    if (hst_ack) begin
                        unique case (wsel)
                            2'd0:    laddr <= LOC_AW'(hst_rdata);
                            2'd1:    haddr <= HOST_AW'(hst_rdata);
                            default: begin
                                remain <= hst_rdata[LEN_W-1:0];
                                last_q <= hst_rdata[LAST_BIT];
                            end
                        endcase
                        wsel <= wsel + 2'd1;
                    end
                end
                ST_SRC: begin
                    if (src_ack) data_q <= (dir_q == DIR_OUT) ? loc_rdata : hst_rdata;
                end
                ST_DST: begin
                    if (dst_ack) begin
                        laddr  <= laddr + LOC_AW'(4);
                        haddr  <= haddr + HOST_AW'(4);
                        remain <= remain - LEN_W'(1);
                    end
                end
                ST_SEG_END: begin
                    desc_ptr <= desc_ptr + HOST_AW'(DESC_BYTE);
                    desc_cnt <= desc_cnt + CNT_W'(1);
                    wsel     <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        hst_req   = 1'b0;
        hst_we    = 1'b0;
        hst_addr  = haddr;
        loc_req   = 1'b0;
        loc_we    = 1'b0;
        fin       = '0;
        fault     = '0;
        stop_ack  = 1'b0;
        done_evt  = 1'b0;
        llerr_evt = 1'b0;
        unique case (state_q)
            ST_IDLE:  stop_ack = stop_q;
            ST_FETCH: begin
                hst_req  = 1'b1;
                hst_addr = desc_ptr + HOST_AW'({wsel, 2'b00});
            end
            ST_SRC: begin
                hst_req = (dir_q == DIR_IN);
                loc_req = (dir_q == DIR_OUT);
            end
            ST_DST: begin
                hst_req = (dir_q == DIR_OUT);
                hst_we  = (dir_q == DIR_OUT);
                loc_req = (dir_q == DIR_IN);
                loc_we  = (dir_q == DIR_IN);
            end
            ST_DONE: begin
                done_evt   = 1'b1;
                fin[dir_q] = 1'b1;
            end
            ST_FAULT: begin
                llerr_evt    = 1'b1;
                fin[dir_q]   = 1'b1;
                fault[dir_q] = 1'b1;
            end
            default: ;
        endcase
    end

    assign loc_addr  = laddr;
    assign hst_wdata = data_q;
    assign loc_wdata = data_q;

endmodule

// File: rtl/ll_dma_engine.sv
module ll_dma_engine
    import ll_dma_pkg::*;
#(
    parameter int REG_AW   = 5,
    parameter int HOST_AW  = 32,
    parameter int LOC_AW   = 24,
    parameter int LEN_W    = 16,
    parameter int MAX_DESC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               hst_req,
    output logic               hst_we,
    output logic [HOST_AW-1:0] hst_addr,
    output logic [31:0]        hst_wdata,
    input  logic               hst_ack,
    input  logic [31:0]        hst_rdata,
    output logic               loc_req,
    output logic               loc_we,
    output logic [LOC_AW-1:0]  loc_addr,
    output logic [31:0]        loc_wdata,
    input  logic               loc_ack,
    input  logic [31:0]        loc_rdata,
    output logic               done_evt,
    output logic               llerr_evt
);

    logic [1:0]  busy, enable, fin, fault;
    logic        stop_q, stop_ack, cancel;
    logic [31:0] in_ptr, out_ptr, status;

    ll_dma_regs #(
        .REG_AW (REG_AW),
        .NDIR   (2)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .fin      (fin),
        .fault    (fault),
        .stop_ack (stop_ack),
        .busy     (busy),
        .enable   (enable),
        .stop_q   (stop_q),
        .cancel   (cancel),
        .in_ptr   (in_ptr),
        .out_ptr  (out_ptr),
        .status   (status)
    );

    ll_dma_seq #(
        .HOST_AW (HOST_AW),
        .LOC_AW  (LOC_AW),
        .LEN_W   (LEN_W),
        .MAX_DESC(MAX_DESC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .stop_q   (stop_q),
        .cancel   (cancel),
        .in_ptr   (in_ptr),
        .out_ptr  (out_ptr),
        .fin      (fin),
        .fault    (fault),
        .stop_ack (stop_ack),
        .hst_req  (hst_req),
        .hst_we   (hst_we),
        .hst_addr (hst_addr),
        .hst_wdata(hst_wdata),
        .hst_ack  (hst_ack),
        .hst_rdata(hst_rdata),
        .loc_req  (loc_req),
        .loc_we   (loc_we),
        .loc_addr (loc_addr),
        .loc_wdata(loc_wdata),
        .loc_ack  (loc_ack),
        .loc_rdata(loc_rdata),
        .done_evt (done_evt),
        .llerr_evt(llerr_evt)
    );

endmodule

// File: rtl/ll_dma_checker.sv
module ll_dma_checker #(
    parameter int REG_AW  = 5,
    parameter int HOST_AW = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        status,
    input logic [1:0]         enable,
    input logic               hst_req,
    input logic               hst_ack,
    input logic [HOST_AW-1:0] hst_addr,
    input logic               loc_req,
    input logic               done_evt,
    input logic               llerr_evt
);

    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr[4:2] == 3'd0);

    p_disabled_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata == 32'd1 && !enable[0] && !status[0]) |=> !status[0]);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'b00) |-> (!hst_req && !loc_req));

    p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_req && loc_req));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && !hst_ack && !(ctrl_wr && reg_wdata == 32'd0))
        |=> (hst_req && $stable(hst_addr)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !done_evt);

    p_fault_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        llerr_evt |=> (status[4] && !llerr_evt));

    p_cancel_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata == 32'd0) |=> (status == 32'd0 && !hst_req && !loc_req));

endmodule

bind ll_dma_engine ll_dma_checker #(
    .REG_AW (REG_AW),
    .HOST_AW(HOST_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .status   (status),
    .enable   (enable),
    .hst_req  (hst_req),
    .hst_ack  (hst_ack),
    .hst_addr (hst_addr),
    .loc_req  (loc_req),
    .done_evt (done_evt),
    .llerr_evt(llerr_evt)
);

// File: tb/ll_dma_engine_tb.sv
`timescale 1ns/1ps
module ll_dma_engine_tb;

    localparam int HLAT = 2;
    localparam int LLAT = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hst_req, hst_we, hst_ack;
    logic [31:0] hst_addr, hst_wdata, hst_rdata;
    logic        loc_req, loc_we, loc_ack;
    logic [23:0] loc_addr;
    logic [31:0] loc_wdata, loc_rdata;
    logic        done_evt, llerr_evt;

    logic [31:0] host_mem [0:255];
    logic [31:0] loc_mem  [0:255];
    int hcnt, lcnt;
    int done_cnt, err_cnt, req_cyc;
    int n_chk, n_bad;
    bit finished;

    always #4 clk = ~clk;

    ll_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_ack(loc_ack), .loc_rdata(loc_rdata),
        .done_evt(done_evt), .llerr_evt(llerr_evt)
    );

    // memory models and event monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            hst_ack <= 1'b0; loc_ack <= 1'b0; hcnt <= 0; lcnt <= 0;
            hst_rdata <= '0; loc_rdata <= '0;
            done_cnt <= 0; err_cnt <= 0; req_cyc <= 0;
        end else begin
            if (done_evt)  done_cnt <= done_cnt + 1;
            if (llerr_evt) err_cnt <= err_cnt + 1;
            if (hst_req || loc_req) req_cyc <= req_cyc + 1;
            hst_ack <= 1'b0;
            if (hst_req && !hst_ack) begin
                if (hcnt == HLAT) begin
                    hst_ack <= 1'b1; hcnt <= 0;
                    if (hst_we) host_mem[hst_addr[9:2]] <= hst_wdata;
                    else        hst_rdata <= host_mem[hst_addr[9:2]];
                end else hcnt <= hcnt + 1;
            end else hcnt <= 0;
            loc_ack <= 1'b0;
            if (loc_req && !loc_ack) begin
                if (lcnt == LLAT) begin
                    loc_ack <= 1'b1; lcnt <= 0;
                    if (loc_we) loc_mem[loc_addr[9:2]] <= loc_wdata;
                    else        loc_rdata <= loc_mem[loc_addr[9:2]];
                end else lcnt <= lcnt + 1;
            end else lcnt <= 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input int w, input logic [31:0] la, input logic [31:0] ha,
                            input logic [31:0] len);
        host_mem[w] = la; host_mem[w+1] = ha; host_mem[w+2] = len;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_rd(5'h04, s);
            if (s[1:0] == 2'b00) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(5'h04, v); chk("R1 status after reset", v, 32'h0);
        reg_rd(5'h10, v); chk("R1 enable after reset", v, 32'h0);
        reg_rd(5'h08, v); chk("R1 inbound ptr after reset", v, 32'h0);
        reg_wr(5'h0C, 32'h0000_0123);
        reg_rd(5'h0C, v); chk("R1 outbound ptr readback", v, 32'h0000_0123);
        reg_rd(5'h00, v); chk("R1 control reads zero", v, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int r0;
        reg_wr(5'h10, 32'h2);
        r0 = req_cyc;
        reg_wr(5'h00, 32'd1);
        reg_rd(5'h04, v); chk("R3 disabled inbound busy", v, 32'h0);
        repeat (6) @(negedge clk);
        chk("R3 no request when disabled", 32'(req_cyc - r0), 32'h0);
    endtask

    task automatic t_inbound_single();
        logic [31:0] v;
        int d0;
        for (int i = 0; i < 4; i++) begin
            host_mem[64+i] = 32'hA0A0_0000 + 32'(i);
            loc_mem[i] = 32'h0;
        end
        put_desc(16, 32'h000, 32'h100, 32'h8000_0004);
        reg_wr(5'h10, 32'h3);
        reg_wr(5'h08, 32'h040);
        d0 = done_cnt;
        reg_wr(5'h00, 32'd1);
        reg_rd(5'h04, v); chk("R2 inbound busy after start", v, 32'h1);
        wait_idle();
        for (int i = 0; i < 4; i++)
            chk("R5 inbound word copied", loc_mem[i], 32'hA0A0_0000 + 32'(i));
        chk("R6 one completion event", 32'(done_cnt - d0), 32'd1);
    endtask

    task automatic t_outbound_chain();
        logic [31:0] v;
        int d0;
        for (int i = 0; i < 8; i++) loc_mem[64+i] = 32'hB100_0000 + 32'(i);
        put_desc(32, 32'h100, 32'h200, 32'h0000_0002);
        put_desc(35, 32'h108, 32'h240, 32'h0000_0003);
        put_desc(38, 32'h114, 32'h280, 32'h8000_0001);
        reg_wr(5'h0C, 32'h080);
        d0 = done_cnt;
        reg_wr(5'h00, 32'd2);
        reg_rd(5'h04, v); chk("R2 outbound busy after start", v, 32'h2);
        wait_idle();
        chk("R4 desc0 word0", host_mem[128], 32'hB100_0000);
        chk("R4 desc0 word1", host_mem[129], 32'hB100_0001);
        chk("R4 desc1 word0", host_mem[144], 32'hB100_0002);
        chk("R5 desc1 word2", host_mem[146], 32'hB100_0004);
        chk("R4 final desc word", host_mem[160], 32'hB100_0005);
        chk("R6 chain completion", 32'(done_cnt - d0), 32'd1);
        reg_rd(5'h04, v); chk("R6 status clear after chain", v, 32'h0);
    endtask

    task automatic t_zero_len();
        logic [31:0] v;
        int e0, d0;
        loc_mem[112] = 32'hC0DE_0001;
        host_mem[176] = 32'h0;
        put_desc(48, 32'h1C0, 32'h2C0, 32'h0000_0001);
        put_desc(51, 32'h1C4, 32'h2C4, 32'h8001_0000);
        reg_wr(5'h0C, 32'h0C0);
        e0 = err_cnt;
        reg_wr(5'h00, 32'd2);
        wait_idle();
        chk("R7 data before bad desc", host_mem[176], 32'hC0DE_0001);
        reg_rd(5'h04, v); chk("R7 outbound fault status", v, 32'h18);
        chk("R7 one fault event", 32'(err_cnt - e0), 32'd1);
        // errors survive a good chain
        loc_mem[0] = 32'h0;
        d0 = done_cnt;
        reg_wr(5'h00, 32'd1);
        wait_idle();
        chk("R12 good chain ran", 32'(done_cnt - d0), 32'd1);
        chk("R12 good chain data", loc_mem[0], 32'hA0A0_0000);
        reg_rd(5'h04, v); chk("R12 error bits kept", v, 32'h18);
        reg_wr(5'h00, 32'd0);
        reg_rd(5'h04, v); chk("R9 cancel clears errors", v, 32'h0);
    endtask

    task automatic t_long_chain();
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin
            host_mem[224+k] = 32'hD000_0000 + 32'(k);
            loc_mem[128+k] = 32'h0;
            put_desc(192 + 3*k, 32'h200 + 32'(4*k), 32'h380 + 32'(4*k), 32'h0000_0001);
        end
        put_desc(216, 32'h240, 32'h380, 32'h8000_0001);
        loc_mem[144] = 32'h5EED_5EED;
        reg_wr(5'h08, 32'h300);
        reg_wr(5'h00, 32'd1);
        wait_idle();
        for (int k = 0; k < 8; k++)
            chk("R8 eight desc moved", loc_mem[128+k], 32'hD000_0000 + 32'(k));
        chk("R8 ninth desc not used", loc_mem[144], 32'h5EED_5EED);
        reg_rd(5'h04, v); chk("R8 inbound fault status", v, 32'h14);
        reg_wr(5'h00, 32'd0);
    endtask

    task automatic t_cancel();
        logic [31:0] v;
        int d0;
        put_desc(20, 32'h300, 32'h000, 32'h8000_0014);
        reg_wr(5'h08, 32'h050);
        d0 = done_cnt;
        reg_wr(5'h00, 32'd1);
        repeat (12) @(negedge clk);
        reg_wr(5'h00, 32'd0);
        chk("R9 requests low after cancel", {30'd0, hst_req, loc_req}, 32'h0);
        reg_rd(5'h04, v); chk("R9 status after cancel", v, 32'h0);
        repeat (40) @(negedge clk);
        chk("R9 no completion after cancel", 32'(done_cnt - d0), 32'd0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int d0;
        for (int i = 0; i < 4; i++) loc_mem[i] = 32'hE000_0000 + 32'(i);
        host_mem[240] = 32'h5A5A_5A5A;
        put_desc(24, 32'h000, 32'h3A0, 32'h0000_0004);
        put_desc(27, 32'h010, 32'h3C0, 32'h8000_0004);
        reg_wr(5'h0C, 32'h060);
        d0 = done_cnt;
        reg_wr(5'h00, 32'd2);
        repeat (3) @(negedge clk);
        reg_wr(5'h00, 32'd4);
        wait_idle();
        chk("R10 current desc finished", host_mem[235], 32'hE000_0003);
        chk("R10 next desc untouched", host_mem[240], 32'h5A5A_5A5A);
        chk("R10 no completion on stop", 32'(done_cnt - d0), 32'd0);
        reg_rd(5'h04, v); chk("R10 status after stop", v, 32'h0);
    endtask

    task automatic t_queue();
        logic [31:0] v;
        int d0;
        reg_wr(5'h08, 32'h040);
        reg_wr(5'h0C, 32'h080);
        d0 = done_cnt;
        reg_wr(5'h00, 32'd1);
        reg_wr(5'h00, 32'd2);
        reg_rd(5'h04, v); chk("R11 both busy", v, 32'h3);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (done_cnt != d0) break;
        end
        reg_rd(5'h04, v); chk("R11 outbound pending after inbound", v, 32'h2);
        wait_idle();
        chk("R11 both chains completed", 32'(done_cnt - d0), 32'd2);
    endtask

    task automatic t_bad_code();
        logic [31:0] v;
        int r0;
        r0 = req_cyc;
        reg_wr(5'h00, 32'd3);
        reg_rd(5'h04, v); chk("R13 code 3 ignored", v, 32'h0);
        repeat (5) @(negedge clk);
        chk("R13 no request for code 3", 32'(req_cyc - r0), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            host_mem[i] = 32'h0;
            loc_mem[i] = 32'h0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_inbound_single();
        t_outbound_chain();
        t_zero_len();
        t_long_chain();
        t_cancel();
        t_stop();
        t_queue();
        t_bad_code();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule